// File: doc/BRIEF.md
# Sv32 Virtual-to-Physical Address Translator

This block sits between a 32-bit RISC-V core and its memory buses and turns virtual addresses into physical ones under the Sv32 scheme with 4 KiB pages. It has two independent request ports. One serves instruction fetch. The other serves data loads and stores, with a write strobe that tells the two apart. Both ports look up the same small, fully associative translation cache. A hit yields the physical address and the permission verdict in the same cycle.

On a miss the port drops its ready output. The block then asks an external page-table walker for the leaf entry of that page. It installs a good result into the cache, and the stalled access completes as a hit one cycle later. A walker error or an invalid leaf completes the stalled access with a page fault, and nothing is installed. The core supplies the translation control word and its current privilege level. A one-cycle flush pulse empties the cache, so that remapped pages are fetched afresh.

Top module: `sv32_xlate`

## Requirements
- R1: When bit 31 of `satp_i` is 0, or when `priv_i` is 3 (machine), each port returns its virtual address unchanged as the physical address, with ready high and fault low in the same cycle, and starts no walk.
- R2: With translation on, a cache hit returns the physical address in the same cycle as the request: upper 20 bits taken from PTE bits [29:10].
- R3: The low 12 bits of the physical address always equal the low 12 bits of the virtual address.
- R4: On a miss, ready stays low and `ptw_req_o` rises the next cycle. `ptw_vpn_o` carries vaddr[31:12] and `ptw_root_o` carries `satp_i[21:0]`, and both hold until `ptw_done_i`. After a good leaf is returned, the waiting access completes in the following cycle as a hit.
- R5: Fault causes are: 12 on the fetch port, 13 for a data load (`dt_we_i`=0), and 15 for a data store (`dt_we_i`=1).
- R6: The PTE flag bits are V=bit 0, R=bit 1, W=bit 2, X=bit 3 and U=bit 4. A fetch needs X, a load needs R and a store needs W. With `priv_i`=0 (user), the access also needs U. A failed check raises fault with ready high.
- R7: If the walker reports `ptw_err_i`, or returns a PTE with V=0, the waiting port shows fault and ready in the `ptw_done_i` cycle. Nothing is cached, so a repeat access walks again.
- R8: A `flush_i` pulse invalidates every cached entry. The next access to any page walks again and uses the walker's current answer.
- R9: The cache holds 4 entries and fills them in round-robin order, starting at entry 0 after reset or a flush. The fifth distinct page evicts the first page filled.
- R10: If both ports miss in the same idle cycle, the fetch page is walked first and the data page after it.
- R11: An access that hits does not start a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| satp_i | input | 32 | Translation control: bit 31 enables, bits [21:0] root page number |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| flush_i | input | 1 | One-cycle pulse that empties the translation cache |
| if_req_i | input | 1 | Fetch request valid |
| if_vaddr_i | input | 32 | Fetch virtual address |
| if_paddr_o | output | 32 | Fetch physical address |
| if_ready_o | output | 1 | Fetch result valid this cycle (low while stalled) |
| if_fault_o | output | 1 | Fetch page fault |
| if_cause_o | output | 4 | Fetch fault cause |
| dt_req_i | input | 1 | Data request valid |
| dt_we_i | input | 1 | Data access is a store |
| dt_vaddr_i | input | 32 | Data virtual address |
| dt_paddr_o | output | 32 | Data physical address |
| dt_ready_o | output | 1 | Data result valid this cycle |
| dt_fault_o | output | 1 | Data page fault |
| dt_cause_o | output | 4 | Data fault cause |
| ptw_req_o | output | 1 | Walk outstanding |
| ptw_vpn_o | output | 20 | Virtual page number to walk |
| ptw_root_o | output | 22 | Root page-table page number |
| ptw_done_i | input | 1 | Walker result valid |
| ptw_pte_i | input | 32 | Leaf PTE from the walker |
| ptw_err_i | input | 1 | Walker found no valid mapping |

## Verification
Two pairs of events can land in one cycle: a fetch miss together with a data miss, and the walker's completion together with a hit on the other port. The bench raises both requests on the same edge, each to a different uncached page. It checks that the first walked page number is the fetch page and that fetch becomes ready before data. It then checks that each port receives its own translation, and that exactly two walks took place.

// File: rtl/sv32_xlate_pkg.sv
package sv32_xlate_pkg;

  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PPN_W   = 20;
  localparam int ROOT_W  = 22;
  localparam int PTE_W   = 32;
  localparam int CAUSE_W = 4;

  localparam logic [1:0] PRIV_USER    = 2'd0;
  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    perm_t            perm;
  } tlb_ent_t;

  function automatic perm_t pte_perm(logic [PTE_W-1:0] pte);
    perm_t p;
    p.u = pte[4];
    p.x = pte[3];
    p.w = pte[2];
    p.r = pte[1];
    return p;
  endfunction

  function automatic logic [PPN_W-1:0] pte_ppn(logic [PTE_W-1:0] pte);
    return pte[PPN_W+9:10];
  endfunction

  function automatic logic pte_usable(logic [PTE_W-1:0] pte, logic err);
    return pte[0] && !err;
  endfunction

  function automatic logic access_ok(acc_e kind, logic [1:0] priv, perm_t p);
    logic need;
    case (kind)
      ACC_FETCH: need = p.x;
      ACC_LOAD:  need = p.r;
      default:   need = p.w;
    endcase
    return need && ((priv != PRIV_USER) || p.u);
  endfunction

  function automatic logic [CAUSE_W-1:0] fault_cause(acc_e kind);
    case (kind)
      ACC_FETCH: return 4'd12;
      ACC_LOAD:  return 4'd13;
      default:   return 4'd15;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] join_pa(logic [PPN_W-1:0] ppn, logic [VA_W-1:0] va);
    return {ppn, va[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/sv32_tlb.sv
module sv32_tlb
  import sv32_xlate_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int NPORTS  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush_i,
  input  logic [NPORTS-1:0][VPN_W-1:0]   look_vpn_i,
  output logic [NPORTS-1:0]              hit_o,
  output logic [NPORTS-1:0][PPN_W-1:0]   hit_ppn_o,
  output perm_t [NPORTS-1:0]             hit_perm_o,
  input  logic                           fill_i,
  input  logic [VPN_W-1:0]               fill_vpn_i,
  input  logic [PPN_W-1:0]               fill_ppn_i,
  input  perm_t                          fill_perm_i
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  tlb_ent_t         ent_q [ENTRIES];
  logic [IDX_W-1:0] rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      for (int e = 0; e < ENTRIES; e++) ent_q[e].valid <= 1'b0;
      rr_q <= '0;
    end else if (fill_i) begin
      ent_q[rr_q] <= '{valid: 1'b1, vpn: fill_vpn_i, ppn: fill_ppn_i, perm: fill_perm_i};
      rr_q        <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_look
    logic [ENTRIES-1:0] match;
    logic [PPN_W-1:0]   sel_ppn;
    perm_t              sel_perm;

    always_comb begin
      sel_ppn  = '0;
      sel_perm = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        match[e] = ent_q[e].valid && (ent_q[e].vpn == look_vpn_i[p]);
        if (match[e]) begin
          sel_ppn  = ent_q[e].ppn;
          sel_perm = ent_q[e].perm;
        end
      end
    end

    assign hit_o[p]      = |match;
    assign hit_ppn_o[p]  = sel_ppn;
    assign hit_perm_o[p] = sel_perm;

    // R9: a page never occupies two entries
    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

    // R8: after a flush pulse nothing can hit
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !hit_o[p]);
  end

endmodule

// File: rtl/sv32_walk_arb.sv
module sv32_walk_arb
  import sv32_xlate_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              miss_i,
  input  logic [1:0][VPN_W-1:0]   vpn_i,
  input  logic                    done_i,
  output logic                    req_o,
  output logic [VPN_W-1:0]        vpn_o,
  output logic [1:0]              grant_o
);

  logic [1:0]       grant_q;
  logic [VPN_W-1:0] vpn_q;

  assign req_o   = |grant_q;
  assign vpn_o   = vpn_q;
  assign grant_o = grant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      vpn_q   <= '0;
    end else if (req_o) begin
      if (done_i) grant_q <= '0;
    end else if (miss_i[0]) begin
      grant_q <= 2'b01;
      vpn_q   <= vpn_i[0];
    end else if (miss_i[1]) begin
      grant_q <= 2'b10;
      vpn_q   <= vpn_i[1];
    end
  end

  // R10: fetch miss wins an idle walker
  a_r10_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && miss_i[0]) |=> (grant_q == 2'b01));

  a_r10_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R4: an outstanding walk keeps its page number
  a_r4_walk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !done_i) |=> (req_o && $stable(vpn_o)));

endmodule

// File: rtl/sv32_xlate.sv
module sv32_xlate
  import sv32_xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          satp_i,
  input  logic [1:0]           priv_i,
  input  logic                 flush_i,
  input  logic                 if_req_i,
  input  logic [31:0]          if_vaddr_i,
  output logic [31:0]          if_paddr_o,
  output logic                 if_ready_o,
  output logic                 if_fault_o,
  output logic [3:0]           if_cause_o,
  input  logic                 dt_req_i,
  input  logic                 dt_we_i,
  input  logic [31:0]          dt_vaddr_i,
  output logic [31:0]          dt_paddr_o,
  output logic                 dt_ready_o,
  output logic                 dt_fault_o,
  output logic [3:0]           dt_cause_o,
  output logic                 ptw_req_o,
  output logic [19:0]          ptw_vpn_o,
  output logic [21:0]          ptw_root_o,
  input  logic                 ptw_done_i,
  input  logic [31:0]          ptw_pte_i,
  input  logic                 ptw_err_i
);

  localparam int NPORTS = 2;

  logic                              xlate_on;
  logic [NPORTS-1:0]                 req;
  logic [NPORTS-1:0][VA_W-1:0]       va;
  logic [NPORTS-1:0][VPN_W-1:0]      look_vpn;
  logic [NPORTS-1:0]                 hit;
  logic [NPORTS-1:0][PPN_W-1:0]      hit_ppn;
  perm_t [NPORTS-1:0]                hit_perm;
  logic [NPORTS-1:0]                 miss;
  logic [NPORTS-1:0]                 walk_fault;
  logic [NPORTS-1:0]                 perm_fault;
  logic [NPORTS-1:0]                 fault;
  logic [NPORTS-1:0]                 ready;
  logic [NPORTS-1:0][VA_W-1:0]       pa;
  logic [NPORTS-1:0][CAUSE_W-1:0]    cause;
  logic [1:0]                        grant;
  logic                              walk_bad;
  logic                              fill;
  logic                              unused_bits;

  assign xlate_on    = satp_i[31] && (priv_i != PRIV_MACHINE);
  assign walk_bad    = !pte_usable(ptw_pte_i, ptw_err_i);
  assign fill        = ptw_req_o && ptw_done_i && !walk_bad && !flush_i;
  assign ptw_root_o  = satp_i[ROOT_W-1:0];
  assign unused_bits = ^satp_i[30:ROOT_W];

  assign req = {dt_req_i, if_req_i};
  assign va  = {dt_vaddr_i, if_vaddr_i};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    acc_e kind;
    assign kind = (p == 0) ? ACC_FETCH : (dt_we_i ? ACC_STORE : ACC_LOAD);

    assign look_vpn[p]   = va[p][VA_W-1:OFF_W];
    assign miss[p]       = req[p] && xlate_on && !hit[p];
    assign walk_fault[p] = grant[p] && ptw_done_i && walk_bad;
    assign perm_fault[p] = hit[p] && !access_ok(kind, priv_i, hit_perm[p]);
    assign fault[p]      = req[p] && xlate_on && (perm_fault[p] || walk_fault[p]);
    assign ready[p]      = !xlate_on || !req[p] || hit[p] || walk_fault[p];
    assign pa[p]         = (xlate_on && hit[p]) ? join_pa(hit_ppn[p], va[p]) : va[p];
    assign cause[p]      = fault_cause(kind);
  end

  assign if_paddr_o = pa[0];
  assign if_ready_o = ready[0];
  assign if_fault_o = fault[0];
  assign if_cause_o = cause[0];
  assign dt_paddr_o = pa[1];
  assign dt_ready_o = ready[1];
  assign dt_fault_o = fault[1];
  assign dt_cause_o = cause[1];

  sv32_tlb #(.ENTRIES(TLB_ENTRIES), .NPORTS(NPORTS)) u_tlb (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .look_vpn_i  (look_vpn),
    .hit_o       (hit),
    .hit_ppn_o   (hit_ppn),
    .hit_perm_o  (hit_perm),
    .fill_i      (fill),
    .fill_vpn_i  (ptw_vpn_o),
    .fill_ppn_i  (pte_ppn(ptw_pte_i)),
    .fill_perm_i (pte_perm(ptw_pte_i))
  );

  sv32_walk_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .miss_i  (miss),
    .vpn_i   (look_vpn),
    .done_i  (ptw_done_i),
    .req_o   (ptw_req_o),
    .vpn_o   (ptw_vpn_o),
    .grant_o (grant)
  );

  // R1: bare or machine mode passes addresses straight through
  a_r1_bare_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_req_i && !satp_i[31]) |-> (dt_paddr_o == dt_vaddr_i && dt_ready_o && !dt_fault_o));

  // R3: page offset is never altered
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    if_paddr_o[OFF_W-1:0] == if_vaddr_i[OFF_W-1:0]);

  // R5: data fault cause follows the access direction
  a_r5_data_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dt_fault_o |-> (dt_cause_o == (dt_we_i ? 4'd15 : 4'd13)));

  // R11: with no port missing, an idle walker stays idle
  a_r11_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptw_req_o && !miss[0] && !miss[1]) |=> !ptw_req_o);

  // R4: a good walk for the data port lets a held request complete next cycle
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && grant[1] && dt_req_i) |=>
      (!(dt_req_i && $stable(dt_vaddr_i) && $stable(satp_i) && $stable(priv_i)) || dt_ready_o));

endmodule

// File: tb/sv32_xlate_test.sv
module sv32_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] satp;
  logic [1:0]  priv;
  logic        flush;
  logic        if_req, dt_req, dt_we;
  logic [31:0] if_va, dt_va;
  logic [31:0] if_pa, dt_pa;
  logic        if_rdy, dt_rdy, if_flt, dt_flt;
  logic [3:0]  if_cause, dt_cause;
  logic        ptw_req, ptw_done, ptw_err;
  logic [19:0] ptw_vpn;
  logic [21:0] ptw_root;
  logic [31:0] ptw_pte;

  int n_chk = 0;
  int n_bad = 0;
  int walks = 0;

  logic [19:0] pt_ppn [16];
  logic [7:0]  pt_flg [16];
  logic        pt_err [16];
  logic [1:0]  lat;

  always #10 clk = ~clk;

  sv32_xlate uut (
    .clk(clk), .rst_n(rst_n), .satp_i(satp), .priv_i(priv), .flush_i(flush),
    .if_req_i(if_req), .if_vaddr_i(if_va), .if_paddr_o(if_pa), .if_ready_o(if_rdy),
    .if_fault_o(if_flt), .if_cause_o(if_cause),
    .dt_req_i(dt_req), .dt_we_i(dt_we), .dt_vaddr_i(dt_va), .dt_paddr_o(dt_pa),
    .dt_ready_o(dt_rdy), .dt_fault_o(dt_flt), .dt_cause_o(dt_cause),
    .ptw_req_o(ptw_req), .ptw_vpn_o(ptw_vpn), .ptw_root_o(ptw_root),
    .ptw_done_i(ptw_done), .ptw_pte_i(ptw_pte), .ptw_err_i(ptw_err)
  );

  // walker model: answers two cycles after a request appears
  assign ptw_pte = {2'b00, pt_ppn[ptw_vpn[3:0]], 2'b00, pt_flg[ptw_vpn[3:0]]};
  assign ptw_err = pt_err[ptw_vpn[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      ptw_done <= 1'b0;
      lat      <= 2'd0;
    end else begin
      ptw_done <= 1'b0;
      if (ptw_req && !ptw_done) begin
        if (lat == 2'd1) begin
          ptw_done <= 1'b1;
          lat      <= 2'd0;
          walks    <= walks + 1;
        end else begin
          lat <= lat + 2'd1;
        end
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_pte(input int vpn, input logic [19:0] ppn, input logic [7:0] flg, input logic err);
    pt_ppn[vpn] = ppn;
    pt_flg[vpn] = flg;
    pt_err[vpn] = err;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic access(input bit port, input logic [31:0] va, input bit we,
                        output logic [31:0] pa, output logic flt, output logic [3:0] cause,
                        output int stalls);
    @(negedge clk);
    if (port) begin dt_req = 1'b1; dt_va = va; dt_we = we; end
    else      begin if_req = 1'b1; if_va = va; end
    stalls = 0;
    #5;
    while (!(port ? dt_rdy : if_rdy) && stalls < 50) begin
      @(negedge clk); #5;
      stalls++;
    end
    pa    = port ? dt_pa : if_pa;
    flt   = port ? dt_flt : if_flt;
    cause = port ? dt_cause : if_cause;
    if_req = 1'b0;
    dt_req = 1'b0;
    dt_we  = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #5;
    chk("R4", "reset walk idle", {31'd0, ptw_req}, 32'd0);
    chk("R1", "reset idle ready", {31'd0, if_rdy}, 32'd1);
  endtask

  task automatic t_bare();
    logic [31:0] pa; logic f; logic [3:0] c; int s; int w0;
    w0 = walks;
    satp = 32'h0000_0123; priv = 2'd0;
    access(1, 32'h1234_5678, 1, pa, f, c, s);
    chk("R1", "bare paddr", pa, 32'h1234_5678);
    chk("R1", "bare fault", {31'd0, f}, 32'd0);
    chk("R1", "bare stalls", s, 0);
    satp = 32'h8000_0123; priv = 2'd3;
    access(0, 32'h0000_7123, 0, pa, f, c, s);
    chk("R1", "machine paddr", pa, 32'h0000_7123);
    chk("R1", "machine no walk", walks - w0, 0);
  endtask

  task automatic t_fill_hit();
    logic [31:0] pa; logic f; logic [3:0] c; int s; int w0;
    priv = 2'd0;
    w0 = walks;
    access(0, 32'h0000_1abc, 0, pa, f, c, s);
    chk("R4", "miss stalls", {31'd0, s != 0}, 32'd1);
    chk("R4", "miss walks once", walks - w0, 1);
    chk("R2", "fetch paddr", pa, 32'h8000_1abc);
    chk("R3", "fetch offset", {20'd0, pa[11:0]}, 32'h0000_0abc);
    w0 = walks;
    access(1, 32'h0000_1ff0, 0, pa, f, c, s);
    chk("R2", "hit paddr", pa, 32'h8000_1ff0);
    chk("R11", "hit no stall", s, 0);
    chk("R11", "hit no walk", walks - w0, 0);
  endtask

  task automatic t_flush();
    logic [31:0] pa; logic f; logic [3:0] c; int s; int w0;
    set_pte(1, 20'h80002, 8'h1F, 1'b0);
    access(1, 32'h0000_1000, 0, pa, f, c, s);
    chk("R8", "stale before flush", pa, 32'h8000_1000);
    do_flush();
    w0 = walks;
    access(1, 32'h0000_1000, 0, pa, f, c, s);
    chk("R8", "new map after flush", pa, 32'h8000_2000);
    chk("R8", "flush forces walk", walks - w0, 1);
  endtask

  task automatic t_perm();
    logic [31:0] pa; logic f; logic [3:0] c; int s;
    do_flush();
    priv = 2'd0;
    access(0, 32'h0000_2000, 0, pa, f, c, s);
    chk("R6", "fetch without X faults", {31'd0, f}, 32'd1);
    chk("R5", "fetch cause", {28'd0, c}, 32'd12);
    access(1, 32'h0000_2004, 0, pa, f, c, s);
    chk("R6", "load with R ok", {31'd0, f}, 32'd0);
    access(1, 32'h0000_4008, 1, pa, f, c, s);
    chk("R6", "store without W faults", {31'd0, f}, 32'd1);
    chk("R5", "store cause", {28'd0, c}, 32'd15);
    access(1, 32'h0000_4008, 0, pa, f, c, s);
    chk("R6", "load on R page ok", {31'd0, f}, 32'd0);
    access(1, 32'h0000_5000, 0, pa, f, c, s);
    chk("R6", "user load without U faults", {31'd0, f}, 32'd1);
    chk("R5", "load cause", {28'd0, c}, 32'd13);
    priv = 2'd1;
    access(1, 32'h0000_5000, 0, pa, f, c, s);
    chk("R6", "supervisor load ok", {31'd0, f}, 32'd0);
    chk("R2", "supervisor paddr", pa, 32'h9000_5000);
    priv = 2'd0;
  endtask

  task automatic t_walk_err();
    logic [31:0] pa; logic f; logic [3:0] c; int s; int w0;
    w0 = walks;
    access(1, 32'h0000_3000, 0, pa, f, c, s);
    chk("R7", "walker error faults", {31'd0, f}, 32'd1);
    chk("R7", "walker error cause", {28'd0, c}, 32'd13);
    access(1, 32'h0000_3000, 0, pa, f, c, s);
    chk("R7", "error not cached", walks - w0, 2);
    access(1, 32'h0000_7000, 1, pa, f, c, s);
    chk("R7", "invalid leaf faults", {31'd0, f}, 32'd1);
    chk("R7", "invalid leaf cause", {28'd0, c}, 32'd15);
  endtask

  task automatic t_rr();
    logic [31:0] pa; logic f; logic [3:0] c; int s; int w0;
    do_flush();
    priv = 2'd1;
    access(1, 32'h0000_1000, 0, pa, f, c, s);
    access(1, 32'h0000_2000, 0, pa, f, c, s);
    access(1, 32'h0000_4000, 0, pa, f, c, s);
    access(1, 32'h0000_5000, 0, pa, f, c, s);
    w0 = walks;
    access(1, 32'h0000_6000, 0, pa, f, c, s);
    chk("R9", "fifth page walks", walks - w0, 1);
    w0 = walks;
    access(1, 32'h0000_2000, 0, pa, f, c, s);
    access(1, 32'h0000_4000, 0, pa, f, c, s);
    access(1, 32'h0000_5000, 0, pa, f, c, s);
    chk("R9", "later pages kept", walks - w0, 0);
    access(1, 32'h0000_1000, 0, pa, f, c, s);
    chk("R9", "first page evicted", walks - w0, 1);
    priv = 2'd0;
  endtask

  task automatic t_both();
    int w0; int if_t; int dt_t; logic [19:0] first_vpn; logic [21:0] root; bit seen;
    logic [31:0] ipa, dpa;
    do_flush();
    w0 = walks; if_t = -1; dt_t = -1; seen = 0; first_vpn = '0; root = '0;
    ipa = '0; dpa = '0;
    @(negedge clk);
    if_req = 1'b1; if_va = 32'h0000_6010;
    dt_req = 1'b1; dt_va = 32'h0000_2020; dt_we = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      #5;
      if (ptw_req && !seen) begin seen = 1; first_vpn = ptw_vpn; root = ptw_root; end
      if (if_rdy && if_t < 0) begin if_t = cyc; ipa = if_pa; end
      if (dt_rdy && dt_t < 0) begin dt_t = cyc; dpa = dt_pa; end
      @(negedge clk);
    end
    if_req = 1'b0; dt_req = 1'b0;
    chk("R10", "first walk is fetch page", {12'd0, first_vpn}, 32'h0000_0006);
    chk("R4", "walk root", {10'd0, root}, {10'd0, satp[21:0]});
    chk("R10", "fetch ready first", {31'd0, (if_t >= 0) && (dt_t > if_t)}, 32'd1);
    chk("R10", "two walks", walks - w0, 2);
    chk("R10", "fetch paddr", ipa, 32'h8000_6010);
    chk("R10", "data paddr", dpa, 32'h9000_2020);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) set_pte(i, 20'h0, 8'h00, 1'b0);
    set_pte(1, 20'h80001, 8'h1F, 1'b0);
    set_pte(2, 20'h90002, 8'h17, 1'b0);
    set_pte(3, 20'h00000, 8'h00, 1'b1);
    set_pte(4, 20'h90004, 8'h13, 1'b0);
    set_pte(5, 20'h90005, 8'h0F, 1'b0);
    set_pte(6, 20'h80006, 8'h1F, 1'b0);
    rst_n = 1'b0; satp = '0; priv = 2'd0; flush = 1'b0;
    if_req = 1'b0; dt_req = 1'b0; dt_we = 1'b0; if_va = '0; dt_va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bare();
    satp = 32'h8000_0123; priv = 2'd0;
    t_fill_hit();
    t_flush();
    t_perm();
    t_walk_err();
    t_rr();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule